// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This unit takes a one-cycle trap strobe that carries a cause word, an exception value and the PC of the faulting instruction. In the clock edge that follows, it picks the next PC and updates the trap bookkeeping registers and the current privilege. Each trap has exactly one of four outcomes:

- a redirect while the hart is already halted in debug mode;
- entry into debug mode on an armed breakpoint;
- delegation to supervisor mode;
- handling in machine mode.

The trap vector bases, the two delegation masks, the per-privilege breakpoint arming bits and the current interrupt-enable bits all come from the surrounding CSR file. The unit holds the privilege register. It also holds the exception PC, cause and value registers for both modes, the debug PC, the debug cause and debug privilege, and the saved-enable and previous-privilege stack fields. It reports the clearing of each interrupt-enable bit, and the loss of the load reservation, as one-cycle pulses to their owners.

A separate privilege load port lets the return path elsewhere in the pipeline set the current privilege. A trap strobe in the same cycle takes precedence over it.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset the PC output is the RESET_PC parameter, privilege is machine (encoding 3), the debug cause is 0, and every exception PC, cause, value and stack field register is 0.
- R2: While the debug cause is nonzero (halted in debug mode), a trap whose cause word equals 3 (breakpoint, interrupt flag clear) sets the PC to DBG_ROM, and any other trap sets it to DBG_EXC. Privilege, all trap registers and all stack fields are left unchanged, and no pulse is raised.
- R3: Outside debug mode, a trap with cause word 3 enters debug mode when the arming bit for the current privilege is set: brk_en_i bit 2 for machine (3), bit 1 for supervisor (1), bit 0 for user (0). This outcome takes priority over delegation. Entry sets the debug cause to 1, copies the privilege into the debug privilege, copies the trap PC into dpc, sets privilege to machine and sets the PC to DBG_ROM. No other register changes and no pulse is raised.
- R4: Bit XLEN-1 of the cause is the interrupt flag, and the low XLEN-1 bits are the cause index. An interrupt is looked up in mideleg_i and an exception in medeleg_i. The trap is delegated only when the privilege is user or supervisor, the index is below XLEN, and the mask bit at that index is set.
- R5: A delegated trap sets the PC to stvec_i, scause to the cause, sepc to the trap PC and stval to the value. It sets SPIE to sie_i and SPP to bit 0 of the old privilege, pulses sie_clr_o, and sets privilege to supervisor.
- R6: A machine trap sets the PC to mtvec_i with bit 0 cleared. When mtvec_i bit 0 is 1 and the trap is an interrupt, four times the cause index is added to that base.
- R7: A machine trap sets mcause to the cause, mepc to the trap PC and mtval to the value. It sets MPIE to mie_i and MPP to the old privilege, pulses mie_clr_o, and sets privilege to machine.
- R8: resv_clr_o is 1 for exactly the cycle after a supervisor or machine trap commits, and 0 at all other times.
- R9: In a cycle with neither a trap strobe nor a privilege load, no output register changes and all pulses are 0.
- R10: A privilege load without a trap sets privilege to priv_val_i, with the value 2 mapped to user (0). A trap in the same cycle overrides the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| trap_valid_i | input | 1 | Trap strobe, one cycle per trap |
| trap_cause_i | input | XLEN | Cause word, top bit is the interrupt flag |
| trap_tval_i | input | XLEN | Exception value |
| trap_pc_i | input | XLEN | PC of the trapping instruction |
| mtvec_i | input | XLEN | Machine vector base, bit 0 selects vectored interrupts |
| stvec_i | input | XLEN | Supervisor vector base |
| medeleg_i | input | XLEN | Exception delegation mask |
| mideleg_i | input | XLEN | Interrupt delegation mask |
| brk_en_i | input | 3 | Breakpoint arming per privilege: bit 2 M, bit 1 S, bit 0 U |
| sie_i | input | 1 | Current supervisor interrupt enable |
| mie_i | input | 1 | Current machine interrupt enable |
| priv_load_i | input | 1 | Load privilege from the return path |
| priv_val_i | input | 2 | Privilege to load |
| pc_o | output | XLEN | Next PC |
| priv_o | output | 2 | Current privilege |
| mepc_o | output | XLEN | Machine exception PC |
| mcause_o | output | XLEN | Machine cause |
| mtval_o | output | XLEN | Machine exception value |
| sepc_o | output | XLEN | Supervisor exception PC |
| scause_o | output | XLEN | Supervisor cause |
| stval_o | output | XLEN | Supervisor exception value |
| dpc_o | output | XLEN | Debug PC |
| dbg_cause_o | output | 3 | Debug cause, nonzero while halted |
| dbg_prv_o | output | 2 | Privilege saved on debug entry |
| spie_o | output | 1 | Saved supervisor interrupt enable |
| spp_o | output | 1 | Previous privilege for supervisor traps |
| mpie_o | output | 1 | Saved machine interrupt enable |
| mpp_o | output | 2 | Previous privilege for machine traps |
| sie_clr_o | output | 1 | Pulse: clear the supervisor interrupt enable |
| mie_clr_o | output | 1 | Pulse: clear the machine interrupt enable |
| resv_clr_o | output | 1 | Pulse: drop the load reservation |

## Verification
Three conditions can hold for the same trap. A breakpoint can be armed for the current privilege and also be delegated by medeleg bit 3. The bench provokes this in supervisor mode and expects debug entry with the supervisor registers untouched. It also applies a trap strobe together with a privilege load, and judges that the trap outcome wins and the loaded value is discarded. Random traps, privilege loads and occasional resets then mix both collisions with all outcomes, and each is compared field by field with a bench model.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam logic [1:0] PRV_U = 2'd0;
  localparam logic [1:0] PRV_S = 2'd1;
  localparam logic [1:0] PRV_H = 2'd2;
  localparam logic [1:0] PRV_M = 2'd3;
  localparam int unsigned BRKPT_CODE = 3;
  localparam logic [2:0] DBG_SWBP = 3'd1;

  typedef enum logic [1:0] {
    RT_DBG_STAY  = 2'd0,
    RT_DBG_ENTER = 2'd1,
    RT_SUP       = 2'd2,
    RT_MACH      = 2'd3
  } route_e;

  function automatic logic [1:0] legal_priv(input logic [1:0] p);
    return (p == PRV_H) ? PRV_U : p;
  endfunction
endpackage

// File: rtl/trap_router.sv
module trap_router
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] cause_i,
  input  logic [1:0]      priv_i,
  input  logic            dbg_active_i,
  input  logic [2:0]      brk_en_i,
  input  logic [XLEN-1:0] medeleg_i,
  input  logic [XLEN-1:0] mideleg_i,
  output route_e          route_o,
  output logic            is_intr_o,
  output logic            is_brk_o
);
  localparam int IW = $clog2(XLEN);
  localparam int CW = XLEN - 1;

  function automatic logic brk_armed(input logic [1:0] p, input logic [2:0] en);
    case (p)
      PRV_M:   return en[2];
      PRV_S:   return en[1];
      PRV_U:   return en[0];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic deleg_hit(input logic [CW-1:0] idx,
                                     input logic [XLEN-1:0] mask);
    if (idx >= CW'(XLEN)) return 1'b0;
    return mask[idx[IW-1:0]];
  endfunction

  logic [CW-1:0]   idx;
  logic [XLEN-1:0] mask_sel;
  logic            low_priv;

  always_comb begin
    is_intr_o = cause_i[XLEN-1];
    idx       = cause_i[CW-1:0];
    is_brk_o  = (cause_i == XLEN'(BRKPT_CODE));
    mask_sel  = is_intr_o ? mideleg_i : medeleg_i;
    low_priv  = (priv_i == PRV_U) || (priv_i == PRV_S);
    if (dbg_active_i)
      route_o = RT_DBG_STAY;
    else if (is_brk_o && brk_armed(priv_i, brk_en_i))
      route_o = RT_DBG_ENTER;
    else if (low_priv && deleg_hit(idx, mask_sel))
      route_o = RT_SUP;
    else
      route_o = RT_MACH;
  end
endmodule

// File: rtl/trap_target.sv
module trap_target
  import trap_pkg::*;
#(
  parameter int          XLEN    = 32,
  parameter logic [31:0] DBG_ROM = 32'h0000_0800,
  parameter logic [31:0] DBG_EXC = 32'h0000_0808
) (
  input  route_e          route_i,
  input  logic            is_intr_i,
  input  logic            is_brk_i,
  input  logic [XLEN-3:0] vec_idx_i,
  input  logic [XLEN-1:0] mtvec_i,
  input  logic [XLEN-1:0] stvec_i,
  output logic [XLEN-1:0] target_o
);
  localparam logic [XLEN-1:0] ROM_ADDR = XLEN'(DBG_ROM);
  localparam logic [XLEN-1:0] EXC_ADDR = XLEN'(DBG_EXC);

  function automatic logic [XLEN-1:0] mvec_addr(input logic [XLEN-1:0] tvec,
                                                input logic intr,
                                                input logic [XLEN-3:0] idx);
    logic [XLEN-1:0] base;
    base = {tvec[XLEN-1:1], 1'b0};
    if (tvec[0] && intr) return base + {idx, 2'b00};
    return base;
  endfunction

  always_comb begin
    case (route_i)
      RT_DBG_STAY:  target_o = is_brk_i ? ROM_ADDR : EXC_ADDR;
      RT_DBG_ENTER: target_o = ROM_ADDR;
      RT_SUP:       target_o = stvec_i;
      default:      target_o = mvec_addr(mtvec_i, is_intr_i, vec_idx_i);
    endcase
  end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter logic [31:0] RESET_PC = 32'h0000_1000,
  parameter logic [31:0] DBG_ROM  = 32'h0000_0800,
  parameter logic [31:0] DBG_EXC  = 32'h0000_0808
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            trap_valid_i,
  input  logic [XLEN-1:0] trap_cause_i,
  input  logic [XLEN-1:0] trap_tval_i,
  input  logic [XLEN-1:0] trap_pc_i,
  input  logic [XLEN-1:0] mtvec_i,
  input  logic [XLEN-1:0] stvec_i,
  input  logic [XLEN-1:0] medeleg_i,
  input  logic [XLEN-1:0] mideleg_i,
  input  logic [2:0]      brk_en_i,
  input  logic            sie_i,
  input  logic            mie_i,
  input  logic            priv_load_i,
  input  logic [1:0]      priv_val_i,
  output logic [XLEN-1:0] pc_o,
  output logic [1:0]      priv_o,
  output logic [XLEN-1:0] mepc_o,
  output logic [XLEN-1:0] mcause_o,
  output logic [XLEN-1:0] mtval_o,
  output logic [XLEN-1:0] sepc_o,
  output logic [XLEN-1:0] scause_o,
  output logic [XLEN-1:0] stval_o,
  output logic [XLEN-1:0] dpc_o,
  output logic [2:0]      dbg_cause_o,
  output logic [1:0]      dbg_prv_o,
  output logic            spie_o,
  output logic            spp_o,
  output logic            mpie_o,
  output logic [1:0]      mpp_o,
  output logic            sie_clr_o,
  output logic            mie_clr_o,
  output logic            resv_clr_o
);
  route_e          route;
  logic            is_intr;
  logic            is_brk;
  logic [XLEN-1:0] target;
  logic            dbg_active;

  // named events for the checker
  logic ev_dbg_stay, ev_dbg_enter, ev_sup, ev_mach;

  assign dbg_active   = (dbg_cause_o != 3'd0);
  assign ev_dbg_stay  = trap_valid_i && (route == RT_DBG_STAY);
  assign ev_dbg_enter = trap_valid_i && (route == RT_DBG_ENTER);
  assign ev_sup       = trap_valid_i && (route == RT_SUP);
  assign ev_mach      = trap_valid_i && (route == RT_MACH);

  trap_router #(.XLEN(XLEN)) u_router (
    .cause_i      (trap_cause_i),
    .priv_i       (priv_o),
    .dbg_active_i (dbg_active),
    .brk_en_i     (brk_en_i),
    .medeleg_i    (medeleg_i),
    .mideleg_i    (mideleg_i),
    .route_o      (route),
    .is_intr_o    (is_intr),
    .is_brk_o     (is_brk)
  );

  trap_target #(.XLEN(XLEN), .DBG_ROM(DBG_ROM), .DBG_EXC(DBG_EXC)) u_target (
    .route_i   (route),
    .is_intr_i (is_intr),
    .is_brk_i  (is_brk),
    .vec_idx_i (trap_cause_i[XLEN-3:0]),
    .mtvec_i   (mtvec_i),
    .stvec_i   (stvec_i),
    .target_o  (target)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pc_o        <= XLEN'(RESET_PC);
      priv_o      <= PRV_M;
      mepc_o      <= '0;
      mcause_o    <= '0;
      mtval_o     <= '0;
      sepc_o      <= '0;
      scause_o    <= '0;
      stval_o     <= '0;
      dpc_o       <= '0;
      dbg_cause_o <= 3'd0;
      dbg_prv_o   <= 2'd0;
      spie_o      <= 1'b0;
      spp_o       <= 1'b0;
      mpie_o      <= 1'b0;
      mpp_o       <= 2'd0;
      sie_clr_o   <= 1'b0;
      mie_clr_o   <= 1'b0;
      resv_clr_o  <= 1'b0;
    end else begin
      sie_clr_o  <= 1'b0;
      mie_clr_o  <= 1'b0;
      resv_clr_o <= 1'b0;
      if (trap_valid_i) begin
        pc_o <= target;
        case (route)
          RT_DBG_STAY: ;
          RT_DBG_ENTER: begin
            dbg_cause_o <= DBG_SWBP;
            dbg_prv_o   <= priv_o;
            dpc_o       <= trap_pc_i;
            priv_o      <= PRV_M;
          end
          RT_SUP: begin
            scause_o   <= trap_cause_i;
            sepc_o     <= trap_pc_i;
            stval_o    <= trap_tval_i;
            spie_o     <= sie_i;
            spp_o      <= priv_o[0];
            sie_clr_o  <= 1'b1;
            priv_o     <= PRV_S;
            resv_clr_o <= 1'b1;
          end
          default: begin
            mcause_o   <= trap_cause_i;
            mepc_o     <= trap_pc_i;
            mtval_o    <= trap_tval_i;
            mpie_o     <= mie_i;
            mpp_o      <= priv_o;
            mie_clr_o  <= 1'b1;
            priv_o     <= PRV_M;
            resv_clr_o <= 1'b1;
          end
        endcase
      end else if (priv_load_i) begin
        priv_o <= legal_priv(priv_val_i);
      end
    end
  end
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk
  import trap_pkg::*;
#(
  parameter int          XLEN    = 32,
  parameter logic [31:0] DBG_ROM = 32'h0000_0800
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            trap_valid_i,
  input logic            priv_load_i,
  input logic [XLEN-1:0] trap_cause_i,
  input logic [XLEN-1:0] trap_pc_i,
  input logic [XLEN-1:0] stvec_i,
  input logic [XLEN-1:0] pc_o,
  input logic [1:0]      priv_o,
  input logic [XLEN-1:0] mepc_o,
  input logic [XLEN-1:0] sepc_o,
  input logic [XLEN-1:0] mcause_o,
  input logic [2:0]      dbg_cause_o,
  input logic            resv_clr_o,
  input logic            ev_dbg_stay,
  input logic            ev_dbg_enter,
  input logic            ev_sup,
  input logic            ev_mach
);
  // R2
  halted_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_i && dbg_cause_o != 3'd0) |-> ev_dbg_stay);

  // R2
  halted_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_dbg_stay |=> ($stable(mepc_o) && $stable(sepc_o) && $stable(priv_o)
                     && $stable(dbg_cause_o)));

  // R3
  dbg_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_dbg_enter |=> (priv_o == PRV_M && dbg_cause_o == DBG_SWBP
                      && pc_o == XLEN'(DBG_ROM)));

  // R5
  sup_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_sup |=> (priv_o == PRV_S && pc_o == $past(stvec_i)
                && sepc_o == $past(trap_pc_i)));

  // R7
  mach_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_mach |=> (priv_o == PRV_M && mcause_o == $past(trap_cause_i)));

  // R8
  resv_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resv_clr_o |-> $past(ev_sup || ev_mach));

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trap_valid_i && !priv_load_i) |=> ($stable(pc_o) && $stable(priv_o)));
endmodule

bind trap_entry_unit trap_entry_chk #(.XLEN(XLEN), .DBG_ROM(DBG_ROM)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .trap_valid_i (trap_valid_i),
  .priv_load_i  (priv_load_i),
  .trap_cause_i (trap_cause_i),
  .trap_pc_i    (trap_pc_i),
  .stvec_i      (stvec_i),
  .pc_o         (pc_o),
  .priv_o       (priv_o),
  .mepc_o       (mepc_o),
  .sepc_o       (sepc_o),
  .mcause_o     (mcause_o),
  .dbg_cause_o  (dbg_cause_o),
  .resv_clr_o   (resv_clr_o),
  .ev_dbg_stay  (ev_dbg_stay),
  .ev_dbg_enter (ev_dbg_enter),
  .ev_sup       (ev_sup),
  .ev_mach      (ev_mach)
);

// File: tb/trap_entry_unit_bench.sv
`timescale 1ns/1ps
module trap_entry_unit_bench;
  localparam logic [31:0] RST_PC = 32'h0000_1000;
  localparam logic [31:0] ROM    = 32'h0000_0800;
  localparam logic [31:0] EXC    = 32'h0000_0808;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tv = 1'b0;
  logic [31:0] cause = '0, tval = '0, tpc = '0;
  logic [31:0] mtvec = '0, stvec = '0, medeleg = '0, mideleg = '0;
  logic [2:0] brk = '0;
  logic sie = 1'b0, mie = 1'b0, pload = 1'b0;
  logic [1:0] pval = '0;

  logic [31:0] pc, mepc, mcause, mtval, sepc, scause, stval, dpc;
  logic [1:0] prv, dprv, mpp;
  logic [2:0] dcause;
  logic spie, spp, mpie, sclr, mclr, rclr;

  trap_entry_unit #(.XLEN(32), .RESET_PC(RST_PC), .DBG_ROM(ROM), .DBG_EXC(EXC))
  u_trap_entry_unit (
    .clk_i(clk), .rst_ni(rst_n), .trap_valid_i(tv), .trap_cause_i(cause),
    .trap_tval_i(tval), .trap_pc_i(tpc), .mtvec_i(mtvec), .stvec_i(stvec),
    .medeleg_i(medeleg), .mideleg_i(mideleg), .brk_en_i(brk), .sie_i(sie),
    .mie_i(mie), .priv_load_i(pload), .priv_val_i(pval), .pc_o(pc),
    .priv_o(prv), .mepc_o(mepc), .mcause_o(mcause), .mtval_o(mtval),
    .sepc_o(sepc), .scause_o(scause), .stval_o(stval), .dpc_o(dpc),
    .dbg_cause_o(dcause), .dbg_prv_o(dprv), .spie_o(spie), .spp_o(spp),
    .mpie_o(mpie), .mpp_o(mpp), .sie_clr_o(sclr), .mie_clr_o(mclr),
    .resv_clr_o(rclr)
  );

  always #4 clk = ~clk;

  int tests = 0;
  int fails = 0;

  // model state
  logic [31:0] e_pc, e_mepc, e_mcause, e_mtval, e_sepc, e_scause, e_stval, e_dpc;
  logic [1:0] e_prv, e_dprv, e_mpp;
  logic [2:0] e_dcause;
  logic e_spie, e_spp, e_mpie, e_sclr, e_mclr, e_rclr;

  task automatic chk(input string tag, input string nm, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, nm, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "pc", pc, e_pc);
    chk(tag, "priv", 32'(prv), 32'(e_prv));
    chk(tag, "mepc", mepc, e_mepc);
    chk(tag, "mcause", mcause, e_mcause);
    chk(tag, "mtval", mtval, e_mtval);
    chk(tag, "sepc", sepc, e_sepc);
    chk(tag, "scause", scause, e_scause);
    chk(tag, "stval", stval, e_stval);
    chk(tag, "dpc", dpc, e_dpc);
    chk(tag, "dcause", 32'(dcause), 32'(e_dcause));
    chk(tag, "dprv", 32'(dprv), 32'(e_dprv));
    chk(tag, "stack", {26'd0, spie, spp, mpie, mpp, 1'b0},
        {26'd0, e_spie, e_spp, e_mpie, e_mpp, 1'b0});
    chk(tag, "sie_clr", 32'(sclr), 32'(e_sclr));
    chk(tag, "mie_clr", 32'(mclr), 32'(e_mclr));
    chk(tag, "resv_clr", 32'(rclr), 32'(e_rclr));
  endtask

  task automatic model_reset();
    e_pc = RST_PC; e_prv = 2'd3; e_mepc = 0; e_mcause = 0; e_mtval = 0;
    e_sepc = 0; e_scause = 0; e_stval = 0; e_dpc = 0; e_dcause = 0; e_dprv = 0;
    e_spie = 0; e_spp = 0; e_mpie = 0; e_mpp = 0; e_sclr = 0; e_mclr = 0; e_rclr = 0;
  endtask

  function automatic logic armed(input logic [1:0] p, input logic [2:0] b);
    if (p == 2'd3) return b[2];
    if (p == 2'd1) return b[1];
    if (p == 2'd0) return b[0];
    return 1'b0;
  endfunction

  function automatic logic delegated(input logic [1:0] p, input logic [31:0] c,
                                     input logic [31:0] ed, input logic [31:0] id);
    logic [31:0] n;
    n = {1'b0, c[30:0]};
    if (p > 2'd1) return 1'b0;
    if (n >= 32) return 1'b0;
    return c[31] ? id[n[4:0]] : ed[n[4:0]];
  endfunction

  function automatic logic [31:0] mach_pc(input logic [31:0] v, input logic [31:0] c);
    logic [31:0] b;
    b = v & 32'hFFFF_FFFE;
    if (v[0] == 1'b1 && c[31] == 1'b1) return b + c[30:0] * 4;
    return b;
  endfunction

  task automatic model_trap();
    e_sclr = 0; e_mclr = 0; e_rclr = 0;
    if (e_dcause != 0) begin
      e_pc = (cause == 32'd3) ? ROM : EXC;
    end else if (cause == 32'd3 && armed(e_prv, brk)) begin
      e_dcause = 3'd1; e_dprv = e_prv; e_dpc = tpc; e_prv = 2'd3; e_pc = ROM;
    end else if (delegated(e_prv, cause, medeleg, mideleg)) begin
      e_pc = stvec; e_scause = cause; e_sepc = tpc; e_stval = tval;
      e_spie = sie; e_spp = e_prv[0]; e_prv = 2'd1; e_sclr = 1; e_rclr = 1;
    end else begin
      e_pc = mach_pc(mtvec, cause); e_mcause = cause; e_mepc = tpc; e_mtval = tval;
      e_mpie = mie; e_mpp = e_prv; e_prv = 2'd3; e_mclr = 1; e_rclr = 1;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tv = 0; pload = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
    check_all("R1");
  endtask

  task automatic do_trap(input logic [31:0] c, input logic [31:0] v,
                         input logic [31:0] p, input string tag,
                         input bit with_load, input logic [1:0] lv);
    cause = c; tval = v; tpc = p; tv = 1; pload = with_load; pval = lv;
    model_trap();
    @(negedge clk);
    check_all(tag);
    tv = 0; pload = 0;
    e_sclr = 0; e_mclr = 0; e_rclr = 0;
    @(negedge clk);
    check_all("R9");
  endtask

  task automatic do_load(input logic [1:0] lv);
    pload = 1; pval = lv;
    e_prv = (lv == 2'd2) ? 2'd0 : lv;
    e_sclr = 0; e_mclr = 0; e_rclr = 0;
    @(negedge clk);
    check_all("R10");
    pload = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    do_reset();

    // R10: value 2 maps to user
    do_load(2'd2);
    // R5 R4: user ecall delegated by medeleg bit 8
    medeleg = 32'h0000_0100; stvec = 32'h0000_4000; sie = 1;
    do_trap(32'd8, 32'hAA, 32'h100, "R5", 0, 0);
    // R4: interrupt delegated from S via mideleg bit 9
    mideleg = 32'h0000_0200; sie = 0;
    do_trap(32'h8000_0009, 32'h0, 32'h104, "R4", 0, 0);
    // R4: index 40 beyond XLEN goes to machine; R6 exception not vectored
    medeleg = 32'hFFFF_FFFF; mtvec = 32'h0000_2001; mie = 1;
    do_trap(32'd40, 32'h55, 32'h108, "R4", 0, 0);
    // R4: machine privilege never delegates
    do_trap(32'd2, 32'h66, 32'h10C, "R7", 0, 0);
    // R6: vectored interrupt, index 7
    mideleg = 0;
    do_trap(32'h8000_0007, 32'h0, 32'h110, "R6", 0, 0);
    // R6: direct mode interrupt
    mtvec = 32'h0000_3000;
    do_trap(32'h8000_000B, 32'h0, 32'h114, "R6", 0, 0);
    // R10: trap wins over simultaneous load
    do_trap(32'd5, 32'h1, 32'h118, "R10", 1, 2'd0);
    // R3: armed breakpoint beats delegation in supervisor
    do_load(2'd1);
    brk = 3'b010; medeleg = 32'h0000_0008;
    do_trap(32'd3, 32'h0, 32'h200, "R3", 0, 0);
    // R2: halted redirects
    do_trap(32'd3, 32'h0, 32'h204, "R2", 0, 0);
    do_trap(32'd5, 32'h9, 32'h208, "R2", 0, 0);
    // R3: unarmed breakpoint in M goes to machine
    do_reset();
    brk = 3'b011;
    do_trap(32'd3, 32'h7, 32'h20C, "R8", 0, 0);

    // random mix
    for (int i = 0; i < 600; i++) begin
      if (i % 40 == 39) do_reset();
      mtvec   = $urandom & 32'hFFFF_FFFD;
      stvec   = $urandom;
      medeleg = $urandom;
      mideleg = $urandom;
      brk     = (($urandom % 6) == 0) ? 3'($urandom) : 3'd0;
      sie     = 1'($urandom);
      mie     = 1'($urandom);
      if (($urandom % 3) == 0) begin
        do_load(2'($urandom));
      end else begin
        logic [31:0] c;
        c = (($urandom % 4) == 0) ? 32'd3 : {1'($urandom), 31'($urandom % 36)};
        do_trap(c, $urandom, $urandom, "R8", (($urandom % 5) == 0), 2'($urandom));
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule